// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Timeout

This block sits beside a standard parallel-port register set and adds the address and data transfer cycles of the enhanced parallel-port protocol. A host issues one access at a time over a simple request/acknowledge bus using a 3-bit register offset. Offset 3 runs an address cycle. Offset 4 runs a data cycle of 1, 2 or 4 bytes. Offset 1 is the status view and offset 2 is the control register. The block also has a separate window flag, `bus_ext`, for the extended register range. In that range every read returns 0xFF and every write is discarded.

Each transfer cycle is allowed only when the control register holds an exact pattern, and the pattern for reads differs from the one for writes. An access that fails the check never reaches the pins and completes at once. Every byte of an allowed access runs a handshake: the block raises a strobe and waits for the peripheral's wait line to go high and then low again. If a byte takes too long, the block sets a sticky timeout flag and abandons the rest of the access. Software reads the flag in status bit 0 and clears it by writing a 1 to that bit.

Top module: `epp_gate`

## Requirements
- R1: After reset, control reads 0xCC, status bit 0 reads 0, both strobes are low and `pp_data_oe` is high.
- R2: A control write stores `wdata[7:0]` with bits 7:6 forced to 1. Control bit 5 (direction) drives `pp_data_oe` inverted, so the data bus is driven while direction is 0.
- R3: A write to offset 3 or 4 runs only when control AND 0x2F equals 0x04. Otherwise no strobe rises and the access is acknowledged one cycle after the request.
- R4: A read from offset 3 or 4 runs only when control AND 0x2F equals 0x24. Otherwise it returns all ones at the access width with the upper bits zero, one cycle after the request.
- R5: Offset 3 uses `pp_addr_stb` and offset 4 uses `pp_data_stb`, never both at once. `pp_write` is high for write cycles. The strobe stays high until `pp_wait_i` has risen and then fallen. A read byte is taken from `pp_data_i` when the wait line is seen high.
- R6: `bus_size` encodes 00 as 1 byte, 01 as 2 bytes and 10 as 4 bytes, and it applies to offset 4 only. Bytes move least significant first on both reads and writes.
- R7: If a byte is not completed within TMO_CYCLES cycles of its strobe rising, the strobe drops and the timeout flag is set. No further bytes of that access are strobed, and bytes not received read as 0xFF.
- R8: A status read returns `pp_status_i[7:1]` with bit 0 replaced by the timeout flag.
- R9: The timeout flag stays set until a status write with bit 0 equal to 1. A status write with bit 0 equal to 0 leaves it unchanged.
- R10: Reads with `bus_ext` high, and reads of offsets 0, 5, 6 and 7, return 0xFF. Writes to those locations change nothing.
- R11: Register accesses are acknowledged one cycle after the request, and write acknowledges return 0 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, sampled while the block is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ext | input | 1 | Access targets the extended register window |
| bus_addr | input | 3 | Register offset |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| pp_status_i | input | 8 | Peripheral status lines |
| pp_data_i | input | 8 | Peripheral data bus, inbound |
| pp_data_o | output | 8 | Peripheral data bus, outbound |
| pp_data_oe | output | 1 | Drive enable for the data bus |
| pp_addr_stb | output | 1 | Address cycle strobe |
| pp_data_stb | output | 1 | Data cycle strobe |
| pp_write | output | 1 | Cycle direction, 1 = write |
| pp_wait_i | input | 1 | Peripheral wait/handshake line |

## Verification
Assertions check on every cycle that the two strobes are never high together and that no strobe stays high past the timeout limit. They also check that control bits 7:6 read as ones, that a gated-off access is acknowledged without a strobe, that a timeout always sets the flag, and that the flag drops only after a status write with bit 0 set. Other behaviour needs the bench scenarios with a peripheral model that answers, stalls or answers only part of the way. Those scenarios show the byte order of wide accesses, the all-ones fill of bytes a timeout cuts off, how many strobes an aborted access issues, and that writes in the wrong mode never reach the pins.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] CTRL_RESET = 8'hCC;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam int         CTRL_DIR_BIT = 5;

  typedef enum logic [1:0] {SZ_ONE = 2'b00, SZ_TWO = 2'b01, SZ_FOUR = 2'b10} acc_size_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_RUN} seq_state_e;
  typedef enum logic [1:0] {EG_IDLE, EG_WAIT_HI, EG_WAIT_LO} eng_state_e;
endpackage

// File: rtl/epp_ctrl_reg.sv
module epp_ctrl_reg
  import epp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       wr_gate_ok,
  output logic       rd_gate_ok,
  output logic       dir_o
);
  logic [7:0] ctrl_d;
  logic [7:0] wr_val;

  always_comb begin
    wr_val = wdata | CTRL_FORCE;
    ctrl_d = ctrl_q;
    if (wr_en && (wr_val != ctrl_q)) ctrl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end

  assign wr_gate_ok = (ctrl_q & GATE_MASK) == GATE_WR;
  assign rd_gate_ok = (ctrl_q & GATE_MASK) == GATE_RD;
  assign dir_o      = ctrl_q[CTRL_DIR_BIT];

  // R2: upper control bits always read as ones
  p_ctrl_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:6] == 2'b11);
endmodule

// File: rtl/epp_byte_engine.sv
module epp_byte_engine
  import epp_gate_pkg::*;
#(
  parameter int TMO_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_addr,
  input  logic       is_write,
  input  logic [7:0] wbyte,
  input  logic       pp_wait_i,
  input  logic [7:0] pp_data_i,
  output logic       done,
  output logic       timeout,
  output logic [7:0] rbyte,
  output logic       addr_stb,
  output logic       data_stb,
  output logic       pp_write,
  output logic [7:0] pp_byte_o
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  eng_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic sel_addr_q, sel_addr_d, wr_q, wr_d;
  logic [7:0] rbyte_q, rbyte_d, byte_q, byte_d;
  logic finish_ok, tmo_hit;

  always_comb begin
    finish_ok = (st_q == EG_WAIT_LO) && !pp_wait_i;
    tmo_hit   = (st_q != EG_IDLE) && (cnt_q == CNT_LAST) && !finish_ok;
    st_d = st_q; cnt_d = cnt_q; sel_addr_d = sel_addr_q; wr_d = wr_q;
    rbyte_d = rbyte_q; byte_d = byte_q;
    unique case (st_q)
      EG_IDLE: if (start) begin
        st_d = EG_WAIT_HI; cnt_d = '0;
        sel_addr_d = is_addr; wr_d = is_write; byte_d = wbyte;
      end
      EG_WAIT_HI: begin
        cnt_d = cnt_q + 1'b1;
        if (tmo_hit) st_d = EG_IDLE;
        else if (pp_wait_i) begin
          st_d = EG_WAIT_LO; rbyte_d = pp_data_i;
        end
      end
      EG_WAIT_LO: begin
        cnt_d = cnt_q + 1'b1;
        if (finish_ok || tmo_hit) st_d = EG_IDLE;
      end
      default: st_d = EG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= EG_IDLE; cnt_q <= '0; sel_addr_q <= 1'b0; wr_q <= 1'b0;
      rbyte_q <= '0; byte_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sel_addr_q <= sel_addr_d; wr_q <= wr_d;
      rbyte_q <= rbyte_d; byte_q <= byte_d;
    end
  end

  assign done      = finish_ok || tmo_hit;
  assign timeout   = tmo_hit;
  assign rbyte     = rbyte_q;
  assign addr_stb  = (st_q != EG_IDLE) && sel_addr_q;
  assign data_stb  = (st_q != EG_IDLE) && !sel_addr_q;
  assign pp_write  = wr_q;
  assign pp_byte_o = byte_q;

  // independent run-length counter for the strobe bound check
  logic [CNT_W-1:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_len_q <= '0;
    else if (addr_stb || data_stb) run_len_q <= run_len_q + 1'b1;
    else                          run_len_q <= '0;
  end

  // R7: a strobe never outlives the timeout window
  p_strobe_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb || data_stb) |-> (run_len_q < CNT_W'(TMO_CYCLES)));
  // R5: address and data strobes are exclusive
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb && data_stb));
endmodule

// File: rtl/epp_gate.sv
module epp_gate
  import epp_gate_pkg::*;
#(
  parameter int TMO_CYCLES = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_ext,
  input  logic [2:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic        bus_ack,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  pp_status_i,
  input  logic [7:0]  pp_data_i,
  output logic [7:0]  pp_data_o,
  output logic        pp_data_oe,
  output logic        pp_addr_stb,
  output logic        pp_data_stb,
  output logic        pp_write,
  input  logic        pp_wait_i
);
  localparam int NBYTES = BUS_W / BYTE_W;

  seq_state_e sq_q, sq_d;
  logic flag_q, flag_d, ack_q, ack_d;
  logic [BUS_W-1:0] rdata_q, rdata_d, wbuf_q, wbuf_d, rbuf_q, rbuf_d, rbuf_upd;
  logic [1:0] idx_q, idx_d, last_q, last_d, last_n;
  logic addr_q, addr_d, wr_q, wr_d;
  logic [BUS_W-1:0] wmask, imm;
  logic [7:0] ctrl_q, stat_view;
  logic wr_ok, rd_ok, dir, accept, epp_hit, go, ctrl_wr, stat_clr;
  logic eng_done, eng_tmo;
  logic [7:0] eng_rbyte;

  epp_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(bus_wdata[7:0]),
    .ctrl_q(ctrl_q), .wr_gate_ok(wr_ok), .rd_gate_ok(rd_ok), .dir_o(dir)
  );

  epp_byte_engine #(.TMO_CYCLES(TMO_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(sq_q == SQ_LAUNCH), .is_addr(addr_q),
    .is_write(wr_q), .wbyte(wbuf_q[{idx_q, 3'b000} +: 8]),
    .pp_wait_i(pp_wait_i), .pp_data_i(pp_data_i), .done(eng_done),
    .timeout(eng_tmo), .rbyte(eng_rbyte), .addr_stb(pp_addr_stb),
    .data_stb(pp_data_stb), .pp_write(pp_write), .pp_byte_o(pp_data_o)
  );

  always_comb begin
    accept  = bus_req && (sq_q == SQ_IDLE);
    epp_hit = !bus_ext && ((bus_addr == OFF_EADDR) || (bus_addr == OFF_EDATA));
    go      = accept && epp_hit && (bus_we ? wr_ok : rd_ok);
    ctrl_wr = accept && bus_we && !bus_ext && (bus_addr == OFF_CTRL);
    stat_clr = accept && bus_we && !bus_ext && (bus_addr == OFF_STAT) && bus_wdata[0];
    if (bus_addr == OFF_EADDR) last_n = 2'd0;
    else begin
      unique case (bus_size)
        SZ_TWO:  last_n = 2'd1;
        SZ_FOUR: last_n = 2'd3;
        default: last_n = 2'd0;
      endcase
    end
    wmask = '0;
    for (int k = 0; k < NBYTES; k++)
      if (k <= int'(last_n)) wmask[k*BYTE_W +: BYTE_W] = 8'hFF;
    stat_view = pp_status_i;
    stat_view[0] = flag_q;
    imm = 32'h0000_00FF;
    if (!bus_ext) begin
      unique case (bus_addr)
        OFF_STAT:             imm = {24'd0, stat_view};
        OFF_CTRL:             imm = {24'd0, ctrl_q};
        OFF_EADDR, OFF_EDATA: imm = wmask;
        default:              imm = 32'h0000_00FF;
      endcase
    end
    rbuf_upd = rbuf_q;
    for (int k = 0; k < NBYTES; k++)
      if (idx_q == k[1:0]) rbuf_upd[k*BYTE_W +: BYTE_W] = eng_rbyte;
  end

  always_comb begin
    sq_d = sq_q; flag_d = flag_q; ack_d = 1'b0; rdata_d = rdata_q;
    wbuf_d = wbuf_q; rbuf_d = rbuf_q; idx_d = idx_q; last_d = last_q;
    addr_d = addr_q; wr_d = wr_q;
    if (stat_clr) flag_d = 1'b0;
    unique case (sq_q)
      SQ_IDLE: if (accept) begin
        if (go) begin
          sq_d = SQ_LAUNCH; wbuf_d = bus_wdata; rbuf_d = wmask;
          idx_d = 2'd0; last_d = last_n;
          addr_d = (bus_addr == OFF_EADDR); wr_d = bus_we;
        end else begin
          ack_d = 1'b1; rdata_d = bus_we ? '0 : imm;
        end
      end
      SQ_LAUNCH: sq_d = SQ_RUN;
      SQ_RUN: if (eng_done) begin
        if (eng_tmo) begin
          flag_d = 1'b1; sq_d = SQ_IDLE; ack_d = 1'b1;
          rdata_d = wr_q ? '0 : rbuf_q;
        end else begin
          rbuf_d = rbuf_upd;
          if (idx_q == last_q) begin
            sq_d = SQ_IDLE; ack_d = 1'b1;
            rdata_d = wr_q ? '0 : rbuf_upd;
          end else begin
            idx_d = idx_q + 1'b1; sq_d = SQ_LAUNCH;
          end
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q <= SQ_IDLE; flag_q <= 1'b0; ack_q <= 1'b0; rdata_q <= '0;
      wbuf_q <= '0; rbuf_q <= '0; idx_q <= '0; last_q <= '0;
      addr_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      sq_q <= sq_d; flag_q <= flag_d; ack_q <= ack_d; rdata_q <= rdata_d;
      wbuf_q <= wbuf_d; rbuf_q <= rbuf_d; idx_q <= idx_d; last_q <= last_d;
      addr_q <= addr_d; wr_q <= wr_d;
    end
  end

  assign bus_ack    = ack_q;
  assign bus_rdata  = rdata_q;
  assign pp_data_oe = !dir;

  // R3: a write in the wrong control pattern completes without a strobe
  p_gate_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bus_we && epp_hit && !wr_ok) |=> (bus_ack && !pp_addr_stb && !pp_data_stb));
  // R4: a read in the wrong control pattern completes without a strobe
  p_gate_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bus_we && epp_hit && !rd_ok) |=> (bus_ack && !pp_addr_stb && !pp_data_stb));
  // R7: an expired byte always leaves the flag set
  p_tmo_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q == SQ_RUN && eng_tmo) |=> flag_q);
  // R9: the flag only drops after a status write with bit 0 set
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(bus_req && bus_we && !bus_ext && bus_addr == OFF_STAT && bus_wdata[0]));
endmodule

// File: tb/epp_gate_bench.sv
module epp_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 24;

  logic clk, rst_n;
  logic bus_req, bus_we, bus_ext, bus_ack;
  logic [2:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0] pp_status_i, pp_data_i, pp_data_o;
  logic pp_data_oe, pp_addr_stb, pp_data_stb, pp_write, pp_wait_i;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [8:0] wlog[$];
  int resp_budget = -1;
  logic [7:0] rd_next = 8'h00;
  int stb_count = 0;

  epp_gate #(.TMO_CYCLES(TMO)) u_epp_gate (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_ext(bus_ext), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .pp_status_i(pp_status_i), .pp_data_i(pp_data_i), .pp_data_o(pp_data_o),
    .pp_data_oe(pp_data_oe), .pp_addr_stb(pp_addr_stb), .pp_data_stb(pp_data_stb),
    .pp_write(pp_write), .pp_wait_i(pp_wait_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results as acknowledges appear
  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      if (exp_q.size() == 0) chk("R11 unexpected ack", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // peripheral model
  initial begin
    pp_wait_i = 1'b0; pp_data_i = 8'h00;
    forever begin
      @(negedge clk);
      if (pp_addr_stb || pp_data_stb) begin
        stb_count++;
        if (resp_budget != 0) begin
          if (resp_budget > 0) resp_budget--;
          repeat (2) @(negedge clk);
          pp_data_i = rd_next; rd_next = rd_next + 8'd1;
          pp_wait_i = 1'b1;
          if (pp_write) wlog.push_back({pp_addr_stb, pp_data_o});
          repeat (2) @(negedge clk);
          pp_wait_i = 1'b0;
        end
        while (pp_addr_stb || pp_data_stb) @(negedge clk);
      end
    end
  end

  task automatic acc(input logic we, input logic ext, input logic [2:0] a,
                     input logic [1:0] sz, input logic [31:0] wd,
                     input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_we = we; bus_ext = ext; bus_addr = a; bus_size = sz; bus_wdata = wd;
    bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    while (!bus_ack) @(negedge clk);
  endtask

  task automatic check_wlog(input string tag, input int n, input logic [8:0] e0,
                            input logic [8:0] e1, input logic [8:0] e2, input logic [8:0] e3);
    logic [8:0] ev[4];
    ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
    chk({tag, " count"}, 32'(wlog.size()), 32'(n));
    for (int i = 0; i < n && wlog.size() > 0; i++) chk(tag, {23'd0, wlog.pop_front()}, {23'd0, ev[i]});
    wlog.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_ext = 1'b0;
    bus_addr = '0; bus_size = '0; bus_wdata = '0; pp_status_i = 8'hA6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes idle", {30'd0, pp_addr_stb, pp_data_stb}, 32'd0);
    chk("R1 data_oe", {31'd0, pp_data_oe}, 32'd1);
    acc(0, 0, 3'd2, 2'b00, 0, 32'hCC, "R1 ctrl reset");
    acc(0, 0, 3'd1, 2'b00, 0, 32'hA6, "R1 R8 status flag clear");
    // R2 control write forcing and direction
    acc(1, 0, 3'd2, 2'b00, 32'h04, 32'h0, "R11 write ack data");
    acc(0, 0, 3'd2, 2'b00, 0, 32'hC4, "R2 ctrl forced bits");
    chk("R2 data_oe write mode", {31'd0, pp_data_oe}, 32'd1);
    // R4 read gated off in write mode
    acc(0, 0, 3'd4, 2'b01, 0, 32'h0000FFFF, "R4 gated read half");
    acc(0, 0, 3'd3, 2'b10, 0, 32'h000000FF, "R4 gated addr read");
    // R5 address write, R6 four-byte write order
    acc(1, 0, 3'd3, 2'b00, 32'h5A, 32'h0, "R5 addr write");
    check_wlog("R5 addr byte", 1, 9'h15A, 0, 0, 0);
    acc(1, 0, 3'd4, 2'b10, 32'h11223344, 32'h0, "R6 word write");
    check_wlog("R6 write order", 4, 9'h044, 9'h033, 9'h022, 9'h011);
    // R3 write gated off by select bit
    acc(1, 0, 3'd2, 2'b00, 32'h0C, 32'h0, "R3 ctrl setup");
    acc(1, 0, 3'd4, 2'b00, 32'h77, 32'h0, "R3 gated write");
    check_wlog("R3 no cycle", 0, 0, 0, 0, 0);
    // switch to read mode
    acc(1, 0, 3'd2, 2'b00, 32'h24, 32'h0, "R2 ctrl read mode");
    chk("R2 data_oe read mode", {31'd0, pp_data_oe}, 32'd0);
    rd_next = 8'h80;
    acc(0, 0, 3'd4, 2'b10, 0, 32'h83828180, "R6 word read order");
    rd_next = 8'h40;
    acc(0, 0, 3'd4, 2'b01, 0, 32'h00004140, "R6 half read");
    rd_next = 8'h3C;
    acc(0, 0, 3'd3, 2'b10, 0, 32'h0000003C, "R5 R6 addr read single byte");
    acc(1, 0, 3'd4, 2'b00, 32'h99, 32'h0, "R3 write in read mode");
    check_wlog("R3 read mode no write", 0, 0, 0, 0, 0);
    // R7 full timeout
    resp_budget = 0; stb_count = 0;
    acc(0, 0, 3'd4, 2'b10, 0, 32'hFFFFFFFF, "R7 timeout read");
    chk("R7 one strobe", 32'(stb_count), 32'd1);
    acc(0, 0, 3'd1, 2'b00, 0, 32'hA7, "R8 flag in status");
    // R9 clear semantics
    acc(1, 0, 3'd1, 2'b00, 32'hFE, 32'h0, "R9 write bit0 zero");
    acc(0, 0, 3'd1, 2'b00, 0, 32'hA7, "R9 flag kept");
    acc(1, 0, 3'd1, 2'b00, 32'h01, 32'h0, "R9 clear");
    acc(0, 0, 3'd1, 2'b00, 0, 32'hA6, "R9 flag cleared");
    // R7 partial timeout
    resp_budget = 1; stb_count = 0; rd_next = 8'h10;
    acc(0, 0, 3'd4, 2'b10, 0, 32'hFFFFFF10, "R7 partial read");
    chk("R7 remaining skipped", 32'(stb_count), 32'd2);
    pp_status_i = 8'h58;
    acc(0, 0, 3'd1, 2'b00, 0, 32'h59, "R8 status lines");
    resp_budget = -1;
    // R10 extended window and unused offsets
    acc(0, 1, 3'd2, 2'b00, 0, 32'hFF, "R10 ext read");
    acc(1, 1, 3'd2, 2'b00, 32'h00, 32'h0, "R10 ext write");
    acc(0, 0, 3'd2, 2'b00, 0, 32'hE4, "R10 ctrl unchanged");
    acc(0, 0, 3'd0, 2'b00, 0, 32'hFF, "R10 offset 0");
    acc(0, 0, 3'd6, 2'b00, 0, 32'hFF, "R10 offset 6");
    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule